// File: doc/BRIEF.md
# Four-Channel Programmable Interval Timer

This block holds four independent 32-bit down-counters behind a small memory-mapped register bus. Each channel has its own 64-byte register window. The channel index sits in the top address bits and the register offset in the low six bits. Software sets a load value and copies it into the counter with a reload write. It then picks continuous or single-shot operation and enables the channel. When the counter expires, the channel raises a pending flag, and that flag drives the channel's interrupt line unless the channel is masked.

Clearing a pending flag is a handshake. A clear write that is accepted starts a short busy window. Software can see the window as a status bit, and further clear writes are ignored while it lasts. Reads are combinational from the address; writes take effect at the clock edge on which `bus_we` is high. Reset is synchronous and active high.

Top module: `quad_interval_timer`

## Requirements
- R1: Address bits [7:6] select the channel and bits [5:0] select the register. Offset 0x04 is the mode (bit 0), 0x08 the 32-bit load value, 0x10 the enable (bit 0) and 0x24 the mask (bit 0). Each of these reads back what was last written to it.
- R2: Offset 0x00 of any channel window is read-only. It returns the pending flags of all channels, with channel n in bit n and all other bits zero.
- R3: Offset 0x18 returns the live counter. While the enable bit is 1 and the counter is nonzero, the counter drops by one per clock. While the enable bit is 0, it holds its value.
- R4: A write of any data to offset 0x14 copies the load value into the counter at that edge. The register reads as zero.
- R5: In continuous mode (mode bit 0 = 0), an enabled channel whose counter is zero sets its pending flag and reloads from the load value. The expiry period is therefore load+1 clocks.
- R6: In single-shot mode (mode bit 0 = 1), the channel sets its pending flag once when it reaches zero and then stays at zero. It is re-armed by a reload write, by writing 1 to the enable bit, or by writing the mode register.
- R7: Offset 0x20 reads the pending flag in bit 0 and the busy flag in bit 1. Writing bit 0 = 1 while not busy clears the pending flag and holds busy high for 4 clocks. Writing bit 0 = 0 has no effect.
- R8: A clear write made while busy is high is ignored.
- R9: Interrupt line n is high exactly when channel n is pending and its mask bit is 0. A masked flag still shows at offsets 0x00 and 0x20.
- R10: When an expiry and an accepted clear fall on the same edge, the pending flag stays set.
- R11: After reset, every counter, load value, mode, enable, mask, pending flag and busy flag is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, acts at the rising edge |
| bus_addr | input | 8 | Byte address: channel in [7:6], offset in [5:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 4 | Per-channel interrupt, pending and not masked |

## Verification
The bench targets a load of zero in continuous mode, where the channel expires every clock. A clear on such a channel must leave the flag set; a design that let the clear win would drop an expiry. It drives clear writes inside the busy window, which a design missing the handshake would accept, emptying the flag early. It checks that a single-shot channel stays silent after its one expiry, since a design that keeps re-firing at zero would set the flag again at once. Random register traffic with small load values then compares every readable register and the interrupt lines against a model built from the requirements.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int CNT_W        = 32;
    localparam int WIN_W        = 6;
    localparam int CLR_BUSY_CYC = 4;

    localparam logic [WIN_W-1:0] OFS_STATUS = 6'h00;
    localparam logic [WIN_W-1:0] OFS_CTRL   = 6'h04;
    localparam logic [WIN_W-1:0] OFS_LOAD   = 6'h08;
    localparam logic [WIN_W-1:0] OFS_RUN    = 6'h10;
    localparam logic [WIN_W-1:0] OFS_RELOAD = 6'h14;
    localparam logic [WIN_W-1:0] OFS_COUNT  = 6'h18;
    localparam logic [WIN_W-1:0] OFS_CLEAR  = 6'h20;
    localparam logic [WIN_W-1:0] OFS_MASK   = 6'h24;

    typedef struct packed {
        logic mode;
        logic load;
        logic run;
        logic reload;
        logic clear;
        logic mask;
    } ch_wr_t;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] load;
        logic             mode;
        logic             run;
        logic             mask;
        logic             pend;
        logic             busy;
    } ch_state_t;

    function automatic logic [CNT_W-1:0] flag_word(input logic b);
        return {{(CNT_W-1){1'b0}}, b};
    endfunction

endpackage

// File: rtl/pit_regdec.sv
module pit_regdec
    import pit_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic                     we_i,
    input  logic [ADDR_W-1:0]        addr_i,
    output ch_wr_t [NUM_CH-1:0]      wr_o
);
    localparam int CH_W = ADDR_W - WIN_W;

    logic [CH_W-1:0]  sel;
    logic [WIN_W-1:0] ofs;

    assign sel = addr_i[ADDR_W-1:WIN_W];
    assign ofs = addr_i[WIN_W-1:0];

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            logic hit;
            hit              = we_i && (sel == CH_W'(c));
            wr_o[c].mode     = hit && (ofs == OFS_CTRL);
            wr_o[c].load     = hit && (ofs == OFS_LOAD);
            wr_o[c].run      = hit && (ofs == OFS_RUN);
            wr_o[c].reload   = hit && (ofs == OFS_RELOAD);
            wr_o[c].clear    = hit && (ofs == OFS_CLEAR);
            wr_o[c].mask     = hit && (ofs == OFS_MASK);
        end
    end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int BUSY_CYC = CLR_BUSY_CYC
) (
    input  logic             clk,
    input  logic             rst,
    input  ch_wr_t           wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output ch_state_t        st_o,
    output logic             irq_o
);
    localparam int BW = $clog2(BUSY_CYC + 1);

    logic [CNT_W-1:0] count_q, load_q;
    logic             mode_q, run_q, mask_q, pend_q, done_q;
    logic [BW-1:0]    busy_q;
    logic             busy, at_zero, expire, clr_go, rearm;

    assign busy    = (busy_q != '0);
    assign at_zero = (count_q == '0);
    assign expire  = run_q && at_zero && !done_q && !wr_i.reload;
    assign clr_go  = wr_i.clear && wdata_i[0] && !busy;
    assign rearm   = wr_i.reload || (wr_i.run && wdata_i[0]) || wr_i.mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            load_q  <= '0;
            mode_q  <= 1'b0;
            run_q   <= 1'b0;
            mask_q  <= 1'b0;
            pend_q  <= 1'b0;
            done_q  <= 1'b0;
            busy_q  <= '0;
        end else begin
            if (wr_i.mode) mode_q <= wdata_i[0];
            if (wr_i.load) load_q <= wdata_i;
            if (wr_i.run)  run_q  <= wdata_i[0];
            if (wr_i.mask) mask_q <= wdata_i[0];

            if (wr_i.reload)
                count_q <= load_q;
            else if (expire)
                count_q <= mode_q ? '0 : load_q;
            else if (run_q && !at_zero)
                count_q <= count_q - 1'b1;

            if (rearm)
                done_q <= 1'b0;
            else if (expire && mode_q)
                done_q <= 1'b1;

            if (expire)
                pend_q <= 1'b1;
            else if (clr_go)
                pend_q <= 1'b0;

            if (clr_go)
                busy_q <= BW'(BUSY_CYC);
            else if (busy)
                busy_q <= busy_q - 1'b1;
        end
    end

    assign irq_o = pend_q && !mask_q;

    always_comb begin
        st_o.count = count_q;
        st_o.load  = load_q;
        st_o.mode  = mode_q;
        st_o.run   = run_q;
        st_o.mask  = mask_q;
        st_o.pend  = pend_q;
        st_o.busy  = busy;
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !wr_i.reload) |=> $stable(count_q)); // R3
    AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (run_q && !at_zero && !wr_i.reload) |=> (count_q == $past(count_q) - 1'b1)); // R3
    AST_RELOAD_COPY: assert property (@(posedge clk) disable iff (rst)
        wr_i.reload |=> (count_q == $past(load_q))); // R4
    AST_SINGLE_PARK: assert property (@(posedge clk) disable iff (rst)
        (mode_q && done_q && !wr_i.reload) |=> (count_q == '0)); // R6
    AST_CLEAR_START: assert property (@(posedge clk) disable iff (rst)
        (wr_i.clear && wdata_i[0] && !busy && !expire) |=> (!pend_q && busy)); // R7
    AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (pend_q && busy) |=> pend_q); // R8

endmodule

// File: rtl/pit_rdmux.sv
module pit_rdmux
    import pit_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]   addr_i,
    input  ch_state_t [NUM_CH-1:0] st_i,
    output logic [CNT_W-1:0]    rdata_o
);
    localparam int CH_W = ADDR_W - WIN_W;

    logic [CH_W-1:0]  sel;
    logic [WIN_W-1:0] ofs;
    ch_state_t        cur;
    logic [CNT_W-1:0] pend_vec;

    assign sel = addr_i[ADDR_W-1:WIN_W];
    assign ofs = addr_i[WIN_W-1:0];
    assign cur = st_i[sel];

    always_comb begin
        pend_vec = '0;
        for (int c = 0; c < NUM_CH; c++) pend_vec[c] = st_i[c].pend;
    end

    always_comb begin
        case (ofs)
            OFS_STATUS: rdata_o = pend_vec;
            OFS_CTRL:   rdata_o = flag_word(cur.mode);
            OFS_LOAD:   rdata_o = cur.load;
            OFS_RUN:    rdata_o = flag_word(cur.run);
            OFS_COUNT:  rdata_o = cur.count;
            OFS_CLEAR:  rdata_o = {{(CNT_W-2){1'b0}}, cur.busy, cur.pend};
            OFS_MASK:   rdata_o = flag_word(cur.mask);
            default:    rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/quad_interval_timer.sv
module quad_interval_timer
    import pit_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = $clog2(NUM_CH) + WIN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    ch_wr_t    [NUM_CH-1:0] wr;
    ch_state_t [NUM_CH-1:0] st;

    pit_regdec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .we_i   (bus_we),
        .addr_i (bus_addr),
        .wr_o   (wr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pit_channel #(.BUSY_CYC(CLR_BUSY_CYC)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .wr_i    (wr[c]),
            .wdata_i (bus_wdata),
            .st_o    (st[c]),
            .irq_o   (irq[c])
        );
    end

    pit_rdmux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_rd (
        .addr_i  (bus_addr),
        .st_i    (st),
        .rdata_o (bus_rdata)
    );

endmodule

// File: tb/tb_quad_interval_timer.sv
module tb_quad_interval_timer;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    quad_interval_timer dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Reference model, written from the requirements
    logic [31:0] m_cnt [NCH];
    logic [31:0] m_load[NCH];
    bit          m_mode[NCH], m_run[NCH], m_mask[NCH], m_pend[NCH], m_done[NCH];
    int          m_busy[NCH];

    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            bit hit, w_mode, w_load, w_run, w_rel, w_clr, w_mask, ev, go;
            if (rst) begin
                m_cnt[c] = 0; m_load[c] = 0; m_mode[c] = 0; m_run[c] = 0;
                m_mask[c] = 0; m_pend[c] = 0; m_done[c] = 0; m_busy[c] = 0;
            end else begin
                hit    = bus_we && (bus_addr[7:6] == 2'(c));
                w_mode = hit && bus_addr[5:0] == 6'h04;
                w_load = hit && bus_addr[5:0] == 6'h08;
                w_run  = hit && bus_addr[5:0] == 6'h10;
                w_rel  = hit && bus_addr[5:0] == 6'h14;
                w_clr  = hit && bus_addr[5:0] == 6'h20;
                w_mask = hit && bus_addr[5:0] == 6'h24;
                ev = m_run[c] && m_cnt[c] == 0 && !m_done[c] && !w_rel;
                go = w_clr && bus_wdata[0] && m_busy[c] == 0;
                if (w_rel) m_cnt[c] = m_load[c];
                else if (ev) m_cnt[c] = m_mode[c] ? 32'd0 : m_load[c];
                else if (m_run[c] && m_cnt[c] != 0) m_cnt[c] = m_cnt[c] - 1;
                if (w_rel || (w_run && bus_wdata[0]) || w_mode) m_done[c] = 0;
                else if (ev && m_mode[c]) m_done[c] = 1;
                if (ev) m_pend[c] = 1;
                else if (go) m_pend[c] = 0;
                if (go) m_busy[c] = 4;
                else if (m_busy[c] != 0) m_busy[c] = m_busy[c] - 1;
                if (w_mode) m_mode[c] = bus_wdata[0];
                if (w_load) m_load[c] = bus_wdata;
                if (w_run)  m_run[c]  = bus_wdata[0];
                if (w_mask) m_mask[c] = bus_wdata[0];
            end
        end
    end

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int c;
        logic [31:0] v;
        c = int'(a[7:6]);
        v = 0;
        case (a[5:0])
            6'h00: for (int k = 0; k < NCH; k++) v[k] = m_pend[k];
            6'h04: v[0] = m_mode[c];
            6'h08: v = m_load[c];
            6'h10: v[0] = m_run[c];
            6'h18: v = m_cnt[c];
            6'h20: begin v[0] = m_pend[c]; v[1] = (m_busy[c] != 0); end
            6'h24: v[0] = m_mask[c];
            default: v = 0;
        endcase
        return v;
    endfunction

    function automatic logic [3:0] exp_irq();
        logic [3:0] v;
        for (int k = 0; k < NCH; k++) v[k] = m_pend[k] && !m_mask[k];
        return v;
    endfunction

    function automatic string tag_of(input logic [5:0] o);
        case (o)
            6'h00: return "R2";
            6'h18: return "R3";
            6'h14: return "R4";
            6'h20: return "R7";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        rd(8'h18, d); check("R11 count ch0", d, 0);
        rd(8'h88, d); check("R11 load ch2", d, 0);
        rd(8'h00, d); check("R11 status", d, 0);
        rd(8'hE0, d); check("R11 clear ch3", d, 0);
        check("R11 irq", 32'(irq), 0);

        // R4 reload with arbitrary data, R3 countdown, R5 continuous expiry
        wr(8'h48, 32'd5);
        wr(8'h54, 32'h0000_ABCD);
        rd(8'h58, d); check("R4 count after reload", d, 5);
        rd(8'h54, d); check("R4 reload reads zero", d, 0);
        wr(8'h44, 32'd0);
        wr(8'h50, 32'd1);
        idle(2);
        rd(8'h58, d); check("R3 countdown", d, 3);
        idle(4);
        rd(8'h40, d); check("R5 status ch1 pending", d, 32'h2);
        rd(8'h58, d); check("R5 auto reload", d, 5);
        wr(8'h50, 32'd0);
        idle(3);
        rd(8'h58, d); check("R3 hold when disabled", d, 4);

        // R9 masking
        check("R9 irq unmasked", 32'(irq), 32'h2);
        wr(8'h64, 32'd1);
        check("R9 irq masked", 32'(irq), 0);
        rd(8'hC0, d); check("R9 status keeps masked flag", d, 32'h2);

        // R7 clear handshake
        wr(8'h60, 32'd0);
        rd(8'h60, d); check("R7 write zero no effect", d, 32'h1);
        wr(8'h60, 32'd1);
        rd(8'h60, d); check("R7 cleared and busy", d, 32'h2);
        idle(5);
        rd(8'h60, d); check("R7 busy ends", d, 0);

        // R10 clear against an expiry every clock, then R8 clear while busy
        wr(8'h88, 32'd0);
        wr(8'h94, 32'd0);
        wr(8'h84, 32'd0);
        wr(8'h90, 32'd1);
        idle(2);
        wr(8'hA0, 32'd1);
        rd(8'hA0, d); check("R10 expiry beats clear", d, 32'h3);
        wr(8'h90, 32'd0);
        wr(8'hA0, 32'd1);
        rd(8'hA0, d); check("R8 clear while busy ignored", d, 32'h3);
        idle(5);
        wr(8'hA0, 32'd1);
        rd(8'hA0, d); check("R7 clear after busy", d, 32'h2);

        // R6 single-shot
        wr(8'hC8, 32'd3);
        wr(8'hD4, 32'd0);
        wr(8'hC4, 32'd1);
        wr(8'hD0, 32'd1);
        idle(6);
        rd(8'h00, d); check("R6 single-shot fired", d, 32'h8);
        rd(8'hD8, d); check("R6 parked at zero", d, 0);
        wr(8'hE0, 32'd1);
        idle(6);
        rd(8'hE0, d); check("R6 no refire", d, 0);
        wr(8'hD4, 32'd1);
        rd(8'hD8, d); check("R6 rearm by reload", d, 3);

        // Random traffic against the model
        for (int i = 0; i < 2500; i++) begin
            logic [5:0] ofs_tab [8];
            logic [7:0] a;
            logic [31:0] wd;
            ofs_tab = '{6'h00, 6'h04, 6'h08, 6'h10, 6'h14, 6'h18, 6'h20, 6'h24};
            if ($urandom_range(0, 9) < 7) begin
                a = {2'($urandom_range(0, 3)), ofs_tab[$urandom_range(0, 7)]};
                if (a[5:0] == 6'h08) wd = $urandom_range(0, 24);
                else if (a[5:0] == 6'h14) wd = $urandom;
                else wd = $urandom_range(0, 3);
                wr(a, wd);
            end else begin
                idle($urandom_range(1, 3));
            end
            a = {2'($urandom_range(0, 3)), ofs_tab[$urandom_range(0, 7)]};
            rd(a, d);
            check(tag_of(a[5:0]), d, exp_read(a));
            check("R9", 32'(irq), 32'(exp_irq()));
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule